// File: doc/BRIEF.md
# UART Interrupt Status and Mask Controller

This block keeps the pending-interrupt state of a memory-mapped UART and turns it into interrupt lines. Event pulses from the receive FIFO, transmit path and modem-signal logic set bits in a raw status vector. Software enables sources through a mask, reads raw or masked status, and acknowledges sources by writing ones to a clear register.

The masked status feeds six registered level outputs. Five of them each carry one source group: receive, transmit, receive timeout, modem status and line error. The sixth is a combined line that is high when any enabled source is pending. The register port is a single-cycle access: a write strobe with address and data, and a read data bus that follows the address combinationally.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset the mask and the raw status read as zero and all six interrupt outputs are low.
- R2: A 1 on bit n of `evt_i` in a cycle sets raw status bit n. The bit stays set until it is cleared and is visible on a raw read in the next cycle. Bit map: 0 ring indicator, 1 CTS, 2 DCD, 3 DSR, 4 receive, 5 transmit, 6 receive timeout, 7 framing, 8 parity, 9 break, 10 overrun.
- R3: A pulse on `tx_data_wr_i`, one for each write to the UART data register, sets raw bit 5.
- R4: A read at address 2 returns the raw status ANDed with the mask. Address 0 reads and writes the mask, and address 1 reads the raw status.
- R5: A write to address 3 clears each raw bit whose written bit is 1 and leaves bits written as 0 unchanged.
- R6: A read at address 3 always returns zero.
- R7: Writes to address 1 and address 2 change neither the raw status nor the mask.
- R8: When a source sets a bit in the same cycle that a clear write targets that bit, the bit ends up set.
- R9: The dedicated outputs carry the OR of the masked bits of their groups: `irq_rx_o` bit 4, `irq_tx_o` bit 5, `irq_rtim_o` bit 6, `irq_modem_o` bits 0 to 3, `irq_err_o` bits 7 to 10.
- R10: `irq_any_o` is the OR of all eleven masked status bits.
- R11: Each output is registered and takes its new value at the clock edge that applies the write or event. It is unchanged before that edge, so a mask write takes effect in the next cycle.
- R12: The mask stores only bits 10 to 0. The upper bits of a mask read are zero whatever value was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select: 0 mask, 1 raw, 2 masked, 3 clear |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data for reg_addr_i |
| evt_i | input | 11 | Per-source set pulses |
| tx_data_wr_i | input | 1 | Data register write seen, sets transmit status |
| irq_any_o | output | 1 | Combined interrupt |
| irq_rx_o | output | 1 | Receive interrupt |
| irq_tx_o | output | 1 | Transmit interrupt |
| irq_rtim_o | output | 1 | Receive timeout interrupt |
| irq_modem_o | output | 1 | Modem status interrupt |
| irq_err_o | output | 1 | Line error interrupt |

## Verification
The bench targets a set and a clear that hit the same bit in the same cycle. A design that let the clear win would drop an event that arrives during the acknowledge. Writes to the status addresses are checked for having no effect, because a design that decoded them as a mask or clear write would corrupt state. The bench probes the group boundaries at bits 3/4 and 6/7, where an off-by-one group mask would route a modem or error source to the wrong line. Output timing is sampled both just before and just after the applying edge, which catches an extra pipeline stage and a combinational path from the mask to the outputs.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  localparam int NUM_SRC = 11;
  localparam int NUM_IRQ = 6;
  localparam int ADDR_W  = 2;

  localparam int BIT_RI    = 0;
  localparam int BIT_CTS   = 1;
  localparam int BIT_DCD   = 2;
  localparam int BIT_DSR   = 3;
  localparam int BIT_RX    = 4;
  localparam int BIT_TX    = 5;
  localparam int BIT_RTIM  = 6;
  localparam int BIT_FRAME = 7;
  localparam int BIT_PAR   = 8;
  localparam int BIT_BRK   = 9;
  localparam int BIT_OVR   = 10;

  localparam logic [ADDR_W-1:0] ADDR_MASK   = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_RAW    = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_MASKED = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_CLR    = 2'd3;

  typedef enum int {
    LINE_ANY   = 0,
    LINE_RX    = 1,
    LINE_TX    = 2,
    LINE_RTIM  = 3,
    LINE_MODEM = 4,
    LINE_ERR   = 5
  } irq_line_e;

  typedef logic [NUM_SRC-1:0] src_vec_t;

  // Status bits that drive a given output line.
  function automatic src_vec_t line_sources(input int line);
    src_vec_t m;
    m = '0;
    case (line)
      LINE_ANY:   m = '1;
      LINE_RX:    m[BIT_RX] = 1'b1;
      LINE_TX:    m[BIT_TX] = 1'b1;
      LINE_RTIM:  m[BIT_RTIM] = 1'b1;
      LINE_MODEM: for (int b = BIT_RI; b <= BIT_DSR; b++) m[b] = 1'b1;
      LINE_ERR:   for (int b = BIT_FRAME; b <= BIT_OVR; b++) m[b] = 1'b1;
      default:    m = '0;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/uart_irq_regif.sv
module uart_irq_regif
  import uart_irq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  src_vec_t          raw_i,
  input  src_vec_t          mask_i,
  output logic              mask_we_o,
  output src_vec_t          mask_wdata_o,
  output src_vec_t          clr_o
);

  localparam int PAD_W = DATA_W - NUM_SRC;

  logic unused_wdata_hi;
  assign unused_wdata_hi = ^reg_wdata_i[DATA_W-1:NUM_SRC];

  // Write decode: only mask and clear addresses have an effect.
  assign mask_we_o    = reg_wr_i && (reg_addr_i == ADDR_MASK);
  assign mask_wdata_o = reg_wdata_i[NUM_SRC-1:0];
  assign clr_o        = (reg_wr_i && (reg_addr_i == ADDR_CLR)) ?
                        reg_wdata_i[NUM_SRC-1:0] : '0;

  always_comb begin
    unique case (reg_addr_i)
      ADDR_MASK:   reg_rdata_o = {{PAD_W{1'b0}}, mask_i};
      ADDR_RAW:    reg_rdata_o = {{PAD_W{1'b0}}, raw_i};
      ADDR_MASKED: reg_rdata_o = {{PAD_W{1'b0}}, raw_i & mask_i};
      default:     reg_rdata_o = '0;
    endcase
  end

  AST_CLR_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (reg_addr_i == ADDR_CLR) |-> (reg_rdata_o == '0)); // R6

  AST_MASKED_WITHIN_MASK: assert property (@(posedge clk) disable iff (rst)
    (reg_addr_i == ADDR_MASKED) |->
      ((reg_rdata_o & ~{{PAD_W{1'b0}}, mask_i}) == '0)); // R4

  AST_MASK_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (reg_addr_i == ADDR_MASK) |-> (reg_rdata_o[DATA_W-1:NUM_SRC] == '0)); // R12

endmodule

// File: rtl/uart_irq_status.sv
module uart_irq_status
  import uart_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  src_vec_t set_i,
  input  src_vec_t clr_i,
  input  logic     mask_we_i,
  input  src_vec_t mask_wdata_i,
  output src_vec_t raw_q_o,
  output src_vec_t mask_q_o,
  output src_vec_t masked_nxt_o
);

  src_vec_t raw_q, raw_d;
  src_vec_t mask_q, mask_d;

  // A set arriving with a clear on the same bit wins.
  assign raw_d  = (raw_q & ~clr_i) | set_i;
  assign mask_d = mask_we_i ? mask_wdata_i : mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q  <= '0;
      mask_q <= '0;
    end else begin
      raw_q  <= raw_d;
      mask_q <= mask_d;
    end
  end

  assign raw_q_o      = raw_q;
  assign mask_q_o     = mask_q;
  assign masked_nxt_o = raw_d & mask_d;

  AST_SET_STICKS: assert property (@(posedge clk) disable iff (rst)
    (set_i != '0) |=> ((raw_q & $past(set_i)) == $past(set_i))); // R8

  AST_CLR_DROPS: assert property (@(posedge clk) disable iff (rst)
    ((clr_i & ~set_i) != '0) |=> ((raw_q & $past(clr_i & ~set_i)) == '0)); // R5

  AST_RAW_QUIET: assert property (@(posedge clk) disable iff (rst)
    (set_i == '0 && clr_i == '0) |=> $stable(raw_q)); // R7

  AST_MASK_QUIET: assert property (@(posedge clk) disable iff (rst)
    !mask_we_i |=> $stable(mask_q)); // R7

  AST_RESET_CLEAN: assert property (@(posedge clk)
    rst |=> (raw_q == '0 && mask_q == '0)); // R1

endmodule

// File: rtl/uart_irq_fanout.sv
module uart_irq_fanout
  import uart_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  src_vec_t           masked_i,
  output logic [NUM_IRQ-1:0] irq_o
);

  logic [NUM_IRQ-1:0] irq_q;

  for (genvar k = 0; k < NUM_IRQ; k++) begin : g_line
    localparam src_vec_t GRP = line_sources(k);

    always_ff @(posedge clk) begin
      if (rst) irq_q[k] <= 1'b0;
      else     irq_q[k] <= |(masked_i & GRP);
    end

    AST_RISE_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
      $rose(irq_q[k]) |-> ($past(masked_i & GRP) != '0)); // R11
  end

  assign irq_o = irq_q;

  AST_ANY_IS_UNION: assert property (@(posedge clk) disable iff (rst)
    irq_q[LINE_ANY] == |irq_q[NUM_IRQ-1:1]); // R10

  AST_RESET_LOW: assert property (@(posedge clk)
    rst |=> (irq_q == '0)); // R1

endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic [10:0]       evt_i,
  input  logic              tx_data_wr_i,
  output logic              irq_any_o,
  output logic              irq_rx_o,
  output logic              irq_tx_o,
  output logic              irq_rtim_o,
  output logic              irq_modem_o,
  output logic              irq_err_o
);

  src_vec_t raw_q, mask_q, masked_nxt, set_vec, clr_vec, mask_wdata;
  logic     mask_we;
  logic [NUM_IRQ-1:0] irq;

  // Data register writes raise the transmit source.
  always_comb begin
    set_vec = evt_i;
    set_vec[BIT_TX] = evt_i[BIT_TX] | tx_data_wr_i;
  end

  uart_irq_regif #(.DATA_W(DATA_W)) u_regif (
    .clk          (clk),
    .rst          (rst),
    .reg_wr_i     (reg_wr_i),
    .reg_addr_i   (reg_addr_i),
    .reg_wdata_i  (reg_wdata_i),
    .reg_rdata_o  (reg_rdata_o),
    .raw_i        (raw_q),
    .mask_i       (mask_q),
    .mask_we_o    (mask_we),
    .mask_wdata_o (mask_wdata),
    .clr_o        (clr_vec)
  );

  uart_irq_status u_status (
    .clk          (clk),
    .rst          (rst),
    .set_i        (set_vec),
    .clr_i        (clr_vec),
    .mask_we_i    (mask_we),
    .mask_wdata_i (mask_wdata),
    .raw_q_o      (raw_q),
    .mask_q_o     (mask_q),
    .masked_nxt_o (masked_nxt)
  );

  uart_irq_fanout u_fanout (
    .clk      (clk),
    .rst      (rst),
    .masked_i (masked_nxt),
    .irq_o    (irq)
  );

  assign irq_any_o   = irq[LINE_ANY];
  assign irq_rx_o    = irq[LINE_RX];
  assign irq_tx_o    = irq[LINE_TX];
  assign irq_rtim_o  = irq[LINE_RTIM];
  assign irq_modem_o = irq[LINE_MODEM];
  assign irq_err_o   = irq[LINE_ERR];

  AST_TX_WRITE_SETS: assert property (@(posedge clk) disable iff (rst)
    tx_data_wr_i |=> raw_q[BIT_TX]); // R3

  AST_LINE_TRACKS_MASK: assert property (@(posedge clk) disable iff (rst)
    (mask_q == '0) |-> !irq_any_o); // R9

endmodule

// File: tb/tb_uart_irq_ctrl.sv
module tb_uart_irq_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_wr = 1'b0;
  logic [1:0]    reg_addr = 2'd0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic [10:0]   evt = '0;
  logic          txw = 1'b0;
  logic irq_any, irq_rx, irq_tx, irq_rtim, irq_modem, irq_err;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  logic [10:0] m_raw  = '0;
  logic [10:0] m_mask = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_irq_ctrl #(.DATA_W(DW)) dut (
    .clk(clk), .rst(rst), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .evt_i(evt),
    .tx_data_wr_i(txw), .irq_any_o(irq_any), .irq_rx_o(irq_rx),
    .irq_tx_o(irq_tx), .irq_rtim_o(irq_rtim), .irq_modem_o(irq_modem),
    .irq_err_o(irq_err)
  );

  task automatic check(input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [DW-1:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  // Write register at next edge; update model per R4/R5/R7/R12.
  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    if (a == 2'd0) m_mask = d[10:0];
    if (a == 2'd3) m_raw  = m_raw & ~d[10:0];
  endtask

  task automatic pulse(input logic [10:0] e, input logic t);
    @(negedge clk);
    evt = e; txw = t;
    @(negedge clk);
    evt = '0; txw = 1'b0;
    m_raw = m_raw | e | (t ? 11'h020 : 11'h000);
  endtask

  function automatic logic [5:0] exp_lines(input logic [10:0] r, input logic [10:0] m);
    logic [10:0] x;
    x = r & m;
    return {|x[10:7], |x[3:0], x[6], x[5], x[4], |x};
  endfunction

  task automatic check_lines(input string req);
    check(req, "irq lines {err,modem,rtim,tx,rx,any}",
          {26'd0, irq_err, irq_modem, irq_rtim, irq_tx, irq_rx, irq_any},
          {26'd0, exp_lines(m_raw, m_mask)});
  endtask

  task automatic check_regs(input string req);
    logic [DW-1:0] d;
    rd(2'd0, d); check(req, "mask read", d, {21'd0, m_mask});
    rd(2'd1, d); check(req, "raw read", d, {21'd0, m_raw});
    rd(2'd2, d); check(req, "masked read", d, {21'd0, m_raw & m_mask});
  endtask

  task automatic t_reset();
    check_regs("R1");
    check_lines("R1");
  endtask

  task automatic t_event_set();
    wr(2'd0, 32'h7FF);
    pulse(11'b000_0001_0000, 1'b0);   // receive
    check_regs("R2");
    check_lines("R9 rx");
    pulse(11'b100_0000_0001, 1'b0);   // overrun + ring
    check_regs("R2");
    check_lines("R9 err/modem");
    wr(2'd3, 32'h7FF);
    check_regs("R5");
  endtask

  task automatic t_tx_write();
    pulse('0, 1'b1);
    check_regs("R3");
    check_lines("R3");
  endtask

  task automatic t_masked_read();
    pulse(11'b101_0101_0101, 1'b0);
    wr(2'd0, 32'h0F0);
    check_regs("R4");
    check_lines("R4");
  endtask

  task automatic t_clear();
    logic [DW-1:0] d;
    wr(2'd3, 32'h005);   // clears bits 0 and 2 only
    check_regs("R5");
    rd(2'd3, d);
    check("R6", "clear read", d, 32'd0);
  endtask

  task automatic t_readonly();
    wr(2'd1, 32'hFFFF_FFFF);
    check_regs("R7 raw write");
    wr(2'd2, 32'h0000_0000);
    check_regs("R7 masked write");
    check_lines("R7");
  endtask

  task automatic t_set_vs_clear();
    @(negedge clk);
    evt = 11'h040; reg_addr = 2'd3; reg_wdata = 32'h040; reg_wr = 1'b1;
    @(negedge clk);
    evt = '0; reg_wr = 1'b0;
    m_raw = m_raw | 11'h040;
    check_regs("R8");
  endtask

  task automatic t_groups();
    wr(2'd3, 32'h7FF);
    wr(2'd0, 32'h7FF);
    for (int b = 0; b < 11; b++) begin
      pulse(11'(1) << b, 1'b0);
      check_lines("R9 R10 single source");
      wr(2'd3, 32'h1 << b);
      check_lines("R9 after clear");
    end
  endtask

  task automatic t_timing();
    pulse(11'h008, 1'b0);  // DSR pending
    wr(2'd0, 32'h000);
    check_lines("R11 masked off");
    @(negedge clk);
    reg_addr = 2'd0; reg_wdata = 32'h008; reg_wr = 1'b1;
    #1;
    check("R11", "before edge", {31'd0, irq_modem}, 32'd0);
    @(negedge clk);
    reg_wr = 1'b0;
    m_mask = 11'h008;
    check("R11", "after edge", {31'd0, irq_modem}, 32'd1);
    check_lines("R11");
  endtask

  task automatic t_mask_width();
    logic [DW-1:0] d;
    wr(2'd0, 32'hFFFF_F000);
    rd(2'd0, d);
    check("R12", "mask upper bits", d, 32'd0);
    wr(2'd0, 32'hABCD_E7FF);
    rd(2'd0, d);
    check("R12", "mask stored bits", d, 32'h7FF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_event_set();
    t_tx_write();
    t_masked_read();
    t_clear();
    t_readonly();
    t_set_vs_clear();
    t_groups();
    t_timing();
    t_mask_width();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule